// File: doc/BRIEF.md
# Half-Rate Command and Write-Data Serializer

This block sits between a memory controller that runs at half the memory clock rate and the full-rate output stage of a DDR memory interface. During each controller cycle the controller presents a word that covers two memory clocks. Every chip-select and command line comes as a two-bit pair: the low bit of the pair is the value for the first memory clock and the high bit is the value for the second. The write data carries four byte beats, and a two-bit valid field gives one bit per memory clock.

The block runs on the memory clock. A phase input is high on the first memory clock of each controller cycle. On that edge the block takes the first-slot half of the word straight to its output registers and stores the second-slot half. One memory clock later it drives the stored half. Each memory clock the write data leaves as a rise byte and a fall byte. When a command is placed in the first slot (unaligned placement), the block raises a one-clock flag. Because the serialization runs without gaps, a command or data burst that starts in the second slot of one controller word and ends in the first slot of the next comes out as one continuous stream.

Top module: `halfrate_serializer`

## Requirements
- R1: While reset is asserted, and after reset until the first word is captured, every mem_cs_n and mem_cmd_n bit is 1, mem_wdv and mem_unaligned are 0, and both data bytes are 0.
- R2: When phase_first is high at a clock edge, bit 2i of ctl_cs_n and bit 2j of ctl_cmd_n appear on mem_cs_n[i] and mem_cmd_n[j] in the following memory clock.
- R3: In the memory clock after that, bits 2i+1 and 2j+1 of the same captured word appear on the same outputs, even if the controller inputs have changed since the capture edge.
- R4: Write bytes go out in order: first clock rise = ctl_wdata[7:0], fall = [15:8]; second clock rise = [23:16], fall = [31:24].
- R5: A chip-select pair of 01 (bit 1 low) drives that chip select low only in the second memory clock. A pair of 10 (bit 0 low) drives it low only in the first memory clock.
- R6: mem_unaligned is 1 for exactly the first-slot memory clock of a word in which any chip-select pair has bit 0 low, and 0 in every other clock.
- R7: mem_wdv follows ctl_wdv[0] in the first clock and ctl_wdv[1] in the second. An unaligned write that has ctl_wdv = 10 in word N and 01 in word N+1 gives two consecutive valid clocks carrying bytes [23:16],[31:24] of N and then [7:0],[15:8] of N+1.
- R8: An idle controller word (all chip selects 11) between two commands adds exactly two chip-select-high memory clocks and nothing else. An aligned command, then an idle word, then an unaligned command leaves exactly two high clocks between the two low ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_first | input | 1 | High on the first memory clock of each controller cycle |
| ctl_cs_n | input | 2*NCS | Chip-select pairs, active low; bit 2i is slot 0 of chip i |
| ctl_cmd_n | input | 2*CMD_W | Command-line pairs; bit 2j is slot 0 of line j |
| ctl_wdata | input | 4*DW | Write data, four byte beats, lowest first |
| ctl_wdv | input | 2 | Write-data valid per slot |
| mem_cs_n | output | NCS | Serialized chip selects |
| mem_cmd_n | output | CMD_W | Serialized command lines |
| mem_dq_rise | output | DW | Byte for the rising half of this memory clock |
| mem_dq_fall | output | DW | Byte for the falling half of this memory clock |
| mem_wdv | output | 1 | Write data valid for this memory clock |
| mem_unaligned | output | 1 | One-clock pulse for a first-slot command |

## Verification
If the second-slot store captures on the wrong edge or drops a field, the second memory clock of the next word shows stale or scrambled bits. The bench drives the inverted word right after each capture edge, so such a fault shows within one memory clock. If the slot or byte selection is wrong, chip select lands in the wrong clock, or the rise and fall bytes trade places, in the very first clock after capture. A broken unaligned flag, or a broken continuation across the word boundary, shows up on the first-slot clock of the affected word.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  localparam int SLOTS_PER_CTL = 2;
  localparam int BEATS_PER_SLOT = 2;

  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;
endpackage

// File: rtl/hrs_slot_pick.sv
module hrs_slot_pick
  import hrs_pkg::*;
#(
  parameter int N = 2
) (
  input  logic [hrs_pkg::SLOTS_PER_CTL*N-1:0] pairs,
  input  slot_e                                 slot,
  output logic [N-1:0]                          bits
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign bits[i] = (slot == SLOT_SECOND) ? pairs[2*i+1] : pairs[2*i];
  end
endmodule

// File: rtl/hrs_upper_hold.sv
module hrs_upper_hold #(
  parameter int W = 8,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= IDLE;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/halfrate_serializer.sv
module halfrate_serializer
  import hrs_pkg::*;
#(
  parameter int NCS   = 2,
  parameter int CMD_W = 4,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  phase_first,
  input  logic [2*NCS-1:0]      ctl_cs_n,
  input  logic [2*CMD_W-1:0]    ctl_cmd_n,
  input  logic [4*DW-1:0]       ctl_wdata,
  input  logic [1:0]            ctl_wdv,
  output logic [NCS-1:0]        mem_cs_n,
  output logic [CMD_W-1:0]      mem_cmd_n,
  output logic [DW-1:0]         mem_dq_rise,
  output logic [DW-1:0]         mem_dq_fall,
  output logic                  mem_wdv,
  output logic                  mem_unaligned
);
  localparam int HOLD_W = NCS + CMD_W + SLOTS_PER_CTL*DW + 1;
  localparam logic [HOLD_W-1:0] HOLD_IDLE =
    {{NCS{1'b1}}, {CMD_W{1'b1}}, {(SLOTS_PER_CTL*DW+1){1'b0}}};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // slot selection
  logic [NCS-1:0]   s0_cs, s1_cs;
  logic [CMD_W-1:0] s0_cmd, s1_cmd;

  hrs_slot_pick #(.N(NCS)) u_cs_s0 (
    .pairs(ctl_cs_n), .slot(SLOT_FIRST), .bits(s0_cs));
  hrs_slot_pick #(.N(NCS)) u_cs_s1 (
    .pairs(ctl_cs_n), .slot(SLOT_SECOND), .bits(s1_cs));
  hrs_slot_pick #(.N(CMD_W)) u_cmd_s0 (
    .pairs(ctl_cmd_n), .slot(SLOT_FIRST), .bits(s0_cmd));
  hrs_slot_pick #(.N(CMD_W)) u_cmd_s1 (
    .pairs(ctl_cmd_n), .slot(SLOT_SECOND), .bits(s1_cmd));

  // second-slot half stored at capture
  logic [HOLD_W-1:0] hold_d, hold_q;
  logic [NCS-1:0]    h_cs;
  logic [CMD_W-1:0]  h_cmd;
  logic [DW-1:0]     h_rise, h_fall;
  logic              h_dv;

  assign hold_d = {s1_cs, s1_cmd, ctl_wdata[3*DW-1:2*DW], ctl_wdata[4*DW-1:3*DW], ctl_wdv[1]};

  hrs_upper_hold #(.W(HOLD_W), .IDLE(HOLD_IDLE)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .en(phase_first), .d(hold_d), .q(hold_q));

  assign {h_cs, h_cmd, h_rise, h_fall, h_dv} = hold_q;

  // next-state for the output stage
  logic [NCS-1:0]   cs_nxt;
  logic [CMD_W-1:0] cmd_nxt;
  logic [DW-1:0]    rise_nxt, fall_nxt;
  logic             dv_nxt, unal_nxt;

  always_comb begin
    if (phase_first) begin
      cs_nxt   = s0_cs;
      cmd_nxt  = s0_cmd;
      rise_nxt = ctl_wdata[DW-1:0];
      fall_nxt = ctl_wdata[2*DW-1:DW];
      dv_nxt   = ctl_wdv[0];
      unal_nxt = ~&s0_cs;
    end else begin
      cs_nxt   = h_cs;
      cmd_nxt  = h_cmd;
      rise_nxt = h_rise;
      fall_nxt = h_fall;
      dv_nxt   = h_dv;
      unal_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mem_cs_n      <= '1;
      mem_cmd_n     <= '1;
      mem_dq_rise   <= '0;
      mem_dq_fall   <= '0;
      mem_wdv       <= 1'b0;
      mem_unaligned <= 1'b0;
    end else begin
      mem_cs_n      <= cs_nxt;
      mem_cmd_n     <= cmd_nxt;
      mem_dq_rise   <= rise_nxt;
      mem_dq_fall   <= fall_nxt;
      mem_wdv       <= dv_nxt;
      mem_unaligned <= unal_nxt;
    end
  end

  // assertions
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  AST_SLOT0_LINES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_first |=> (mem_cs_n == $past(s0_cs)) && (mem_cmd_n == $past(s0_cmd))); // R2

  AST_SLOT1_LINES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age == 2'd2 && $past(phase_first, 2) && !$past(phase_first))
      |-> (mem_cs_n == $past(s1_cs, 2)) && (mem_cmd_n == $past(s1_cmd, 2))); // R3

  AST_FIRST_BYTES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_first |=> (mem_dq_rise == $past(ctl_wdata[DW-1:0])) &&
                    (mem_dq_fall == $past(ctl_wdata[2*DW-1:DW]))); // R4

  AST_SECOND_BYTES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age == 2'd2 && $past(phase_first, 2) && !$past(phase_first))
      |-> (mem_dq_rise == $past(ctl_wdata[3*DW-1:2*DW], 2)) &&
          (mem_dq_fall == $past(ctl_wdata[4*DW-1:3*DW], 2))); // R4

  AST_UNAL_ONLY_SLOT0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_unaligned |-> $past(phase_first)); // R6

  AST_UNAL_SEEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_first && !(&s0_cs)) |=> mem_unaligned && !(&mem_cs_n)); // R6

  AST_DV_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_first |=> mem_wdv == $past(ctl_wdv[0])); // R7
endmodule

// File: tb/sim_halfrate_serializer.sv
module sim_halfrate_serializer;
  localparam int NCS = 2, CMD_W = 4, DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_first = 1'b0;
  logic [2*NCS-1:0]   ctl_cs_n = '1;
  logic [2*CMD_W-1:0] ctl_cmd_n = '1;
  logic [4*DW-1:0]    ctl_wdata = '0;
  logic [1:0]         ctl_wdv = '0;
  logic [NCS-1:0]     mem_cs_n;
  logic [CMD_W-1:0]   mem_cmd_n;
  logic [DW-1:0]      mem_dq_rise, mem_dq_fall;
  logic               mem_wdv, mem_unaligned;

  always #10 clk = ~clk;

  halfrate_serializer #(.NCS(NCS), .CMD_W(CMD_W), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_first(phase_first),
    .ctl_cs_n(ctl_cs_n), .ctl_cmd_n(ctl_cmd_n), .ctl_wdata(ctl_wdata),
    .ctl_wdv(ctl_wdv), .mem_cs_n(mem_cs_n), .mem_cmd_n(mem_cmd_n),
    .mem_dq_rise(mem_dq_rise), .mem_dq_fall(mem_dq_fall),
    .mem_wdv(mem_wdv), .mem_unaligned(mem_unaligned));

  typedef struct packed {
    logic [NCS-1:0]   cs;
    logic [CMD_W-1:0] cmd;
    logic [DW-1:0]    rise;
    logic [DW-1:0]    fall;
    logic             dv;
    logic             unal;
  } slot_t;

  slot_t exp_q[$];
  string tag_q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  function automatic slot_t observed();
    slot_t o;
    o.cs = mem_cs_n; o.cmd = mem_cmd_n; o.rise = mem_dq_rise;
    o.fall = mem_dq_fall; o.dv = mem_wdv; o.unal = mem_unaligned;
    return o;
  endfunction

  task automatic check(input slot_t act, input slot_t exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got cs=%b cmd=%b rise=%h fall=%h dv=%b unal=%b, expected cs=%b cmd=%b rise=%h fall=%h dv=%b unal=%b",
               tag, act.cs, act.cmd, act.rise, act.fall, act.dv, act.unal,
               exp.cs, exp.cmd, exp.rise, exp.fall, exp.dv, exp.unal);
    end
  endtask

  // driver: one controller word over two memory clocks
  task automatic drive_word(input logic [2*NCS-1:0] cs, input logic [2*CMD_W-1:0] cmd,
                            input logic [4*DW-1:0] data, input logic [1:0] dv,
                            input string tag);
    slot_t e0, e1;
    for (int i = 0; i < NCS; i++) begin
      e0.cs[i] = cs[2*i];
      e1.cs[i] = cs[2*i+1];
    end
    for (int j = 0; j < CMD_W; j++) begin
      e0.cmd[j] = cmd[2*j];
      e1.cmd[j] = cmd[2*j+1];
    end
    e0.rise = data[7:0];   e0.fall = data[15:8];
    e1.rise = data[23:16]; e1.fall = data[31:24];
    e0.dv = dv[0]; e1.dv = dv[1];
    e0.unal = (e0.cs != '1);
    e1.unal = 1'b0;
    @(negedge clk);
    phase_first = 1'b1;
    ctl_cs_n = cs; ctl_cmd_n = cmd; ctl_wdata = data; ctl_wdv = dv;
    exp_q.push_back(e0); tag_q.push_back(tag);
    @(negedge clk);
    phase_first = 1'b0;
    ctl_cs_n = ~cs; ctl_cmd_n = ~cmd; ctl_wdata = ~data; ctl_wdv = ~dv; // R3: inputs change after capture
    exp_q.push_back(e1); tag_q.push_back(tag);
  endtask

  // monitor: scoreboard pop, a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      slot_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(observed(), e, t);
    end
  end

  localparam slot_t IDLE_SLOT = '{cs: '1, cmd: '1, rise: '0, fall: '0, dv: 1'b0, unal: 1'b0};
  localparam logic [2*NCS-1:0] CS_IDLE = '1;
  localparam logic [2*CMD_W-1:0] CMD_IDLE = '1;

  initial begin
    repeat (3) @(negedge clk);
    check(observed(), IDLE_SLOT, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(observed(), IDLE_SLOT, "R1 after release");

    // aligned write on chip 0 (pair 01), then idle
    drive_word(4'b11_01, 8'b10_01_00_11, 32'hA1B2_C3D4, 2'b10, "R5 R2 aligned");
    drive_word(CS_IDLE, CMD_IDLE, 32'h0, 2'b00, "R2 idle");

    // unaligned write crossing the word boundary
    drive_word(4'b11_10, 8'b01_10_11_00, 32'h4433_2211, 2'b10, "R7 R6 unaligned head");
    drive_word(CS_IDLE, CMD_IDLE, 32'h8877_6655, 2'b01, "R7 unaligned tail");

    // spaced: aligned, idle word, unaligned
    drive_word(4'b11_01, 8'b11_11_01_01, 32'h0, 2'b00, "R8 first cmd");
    drive_word(CS_IDLE, CMD_IDLE, 32'h0, 2'b00, "R8 gap");
    drive_word(4'b10_11, 8'b11_11_10_10, 32'h0, 2'b00, "R8 R6 second cmd");

    // chip 1 first slot with chip 0 second slot in one word
    drive_word(4'b10_01, 8'b00_11_01_10, 32'hDEAD_BEEF, 2'b11, "R6 R5 mixed");

    // several byte patterns
    for (int k = 0; k < 6; k++)
      drive_word(CS_IDLE, CMD_IDLE, 32'h0102_0304 * (k + 3) + 32'h1357_9BDF * k,
                 2'(k), "R4 byte order");

    drive_word(CS_IDLE, CMD_IDLE, 32'h0, 2'b00, "R2 drain");
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got no end, expected end of test");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule